// File: doc/BRIEF.md
# Multi-Channel Converter Mode Sequencer

This block is the control state machine that sits in front of a multi-channel sampling converter. Software writes an 8-bit control word. Its top three bits choose an operation: stay idle, scan the enabled channels without stopping, convert one chosen channel once, stand by, or run one of four calibrations. The calibrations are two on the converter itself and two on a chosen channel. The sequencer issues a start pulse for each operation to a conversion engine. That engine is modelled here as a down-counter loaded with the channel's programmed conversion time, or with a fixed calibration length. When the engine reports done, the sequencer raises a write strobe for the channel data register or for one of four calibration registers.

Per-channel ready flags and an active-low ready pin tell the host that results are waiting. A read of a channel's data clears that channel's flag. One-shot operations (single conversion and every calibration) clear the mode field when they finish, so the sequencer drops back to idle by itself. Continuous scanning keeps running until a new control word arrives. Any control write cancels the operation in flight at once, and no register is updated for the cancelled operation.

Top module: `mode_sequencer`

## Requirements
- R1: After reset the control word is 0x00, every ready flag is 0, `ready_n` is 1, and no start, data-write or calibration-write strobe is active.
- R2: Bits 7:5 of the control word hold the mode: 0 idle, 1 continuous, 2 single, 3 standby, 4 converter zero-scale calibration, 5 converter full-scale calibration, 6 channel zero-scale calibration, 7 channel full-scale calibration. In idle no start is ever issued. A single conversion on a channel with conversion time L raises `conv_start` in the cycle after the write edge, raises `data_wr` L cycles later, and sets the ready flag on the edge that follows.
- R3: A single conversion runs on `target_ch` even when that channel is disabled. On completion it sets only that channel's flag and drives `ready_n` low. It clears bits 7:5 to 0 and leaves bits 4:0 unchanged.
- R4: In continuous mode the channels are converted in ascending index order, wrapping from the highest index to the lowest. Disabled channels are skipped, and each completion sets that channel's ready flag.
- R5: In continuous mode conversions run back to back, so the same channel starts again after a number of cycles equal to the sum of the conversion times of all enabled channels.
- R6: Continuous mode with no channel enabled keeps mode 1, issues no start and sets no ready flag.
- R7: Modes 4 and 5 run for CAL_CYCLES cycles. On completion they pulse bit 0 (mode 4) or bit 1 (mode 5) of `cal_wr`, set every ready flag and clear the mode field.
- R8: Modes 6 and 7 run on `target_ch`. On completion they pulse bit 2 (mode 6) or bit 3 (mode 7) of `cal_wr`, with `cal_ch` equal to that channel. They set every ready flag and clear the mode field.
- R9: In standby `standby` is 1 and no start is issued. Control writes are still accepted.
- R10: While bit 4 of the control word is 1 and `xtal_clk` is 1, no start or completion occurs and a running operation is frozen. With `xtal_clk` at 0, bit 4 has no effect on operation.
- R11: A pulse on `rd_strobe` clears the ready flag of `rd_ch`. `ready_n` is 1 exactly when no flag is set.
- R12: A control write during an operation aborts it. The aborted operation produces no data or calibration write and changes no ready flag, and the new mode takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control-word write strobe |
| cfg_wdata | input | 8 | Control word to write |
| cfg_q | output | 8 | Current control word |
| ch_enable | input | NCH | Per-channel scan enable |
| ch_conv_time | input | NCH*TW | Per-channel conversion time in cycles, channel i in bits i*TW +: TW (0 is treated as 1) |
| target_ch | input | CW | Channel for single conversion and channel calibrations |
| xtal_clk | input | 1 | 1 when the converter clock comes from a crystal |
| rd_strobe | input | 1 | Channel data read pulse |
| rd_ch | input | CW | Channel being read |
| conv_start | output | 1 | Start pulse to the conversion engine |
| conv_ch | output | CW | Channel for the start pulse |
| conv_done | output | 1 | Engine completion pulse |
| data_wr | output | 1 | Channel data/status register update strobe |
| data_ch | output | CW | Channel being updated |
| cal_wr | output | 4 | One-hot calibration register update strobe |
| cal_ch | output | CW | Channel for a channel calibration update |
| ready_bits | output | NCH | Per-channel ready flags |
| ready_n | output | 1 | Active-low ready pin |
| standby | output | 1 | Converter powered down |

## Verification
The properties assume that `rd_ch` and `target_ch` stay below NCH. They also assume that `ch_enable` and `ch_conv_time` do not change while a continuous scan is running, since the back-to-back check relates a completion to the channel chosen before it. The stimulus changes enables and times only while the sequencer is idle or just before a control write, and it uses only valid channel numbers. Control writes last one cycle and are spaced well apart, so every cancelled operation has a quiet window in which the absence of strobes can be observed.

// File: rtl/mseq_pkg.sv
// Shared encodings for the mode sequencer.
// Assumes the mode field sits in the top three bits of the control word.
package mseq_pkg;
    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_CONT    = 3'd1,
        MD_SINGLE  = 3'd2,
        MD_STBY    = 3'd3,
        MD_SELF_ZS = 3'd4,
        MD_SELF_FS = 3'd5,
        MD_SYS_ZS  = 3'd6,
        MD_SYS_FS  = 3'd7
    } mode_e;

    localparam int MODE_LSB   = 5;
    localparam int CLKOFF_BIT = 4;
endpackage

// File: rtl/conv_timer.sv
// Abstract conversion engine: a down-counter loaded on start.
// done is high in the cycle the count reaches 1; hold freezes the count.
// Assumes start is not raised while hold is high.
module conv_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hold,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          busy,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    // Count register: cleared on abort, loaded on start, decremented otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (start)
            cnt_q <= (len == '0) ? TW'(1) : len;
        else if (!hold && cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    // Status decode.
    always_comb begin
        busy = (cnt_q != '0);
        done = (cnt_q == TW'(1)) && !hold;
    end
endmodule

// File: rtl/chan_picker.sv
// Round-robin search for the next enabled channel strictly after 'last',
// wrapping round and coming back to 'last' itself after all others.
module chan_picker #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [CW-1:0]  last,
    input  logic [NCH-1:0] en,
    output logic           found,
    output logic [CW-1:0]  next
);
    // Scan from farthest to nearest so the nearest enabled channel wins.
    always_comb begin
        found = 1'b0;
        next  = '0;
        for (int k = NCH; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % NCH;
            if (en[idx]) begin
                found = 1'b1;
                next  = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/ready_tracker.sv
// Per-channel ready flags and the active-low summary pin.
// A set and a clear of the same flag in one cycle leave the flag set.
module ready_tracker #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_one,
    input  logic [CW-1:0]  set_ch,
    input  logic           set_all,
    input  logic           clr,
    input  logic [CW-1:0]  clr_ch,
    output logic [NCH-1:0] bits,
    output logic           rdy_n
);
    logic [NCH-1:0] set_mask, clr_mask;

    // Build the set and clear masks.
    always_comb begin
        set_mask = set_all ? '1 : (set_one ? (NCH'(1) << set_ch) : '0);
        clr_mask = clr ? (NCH'(1) << clr_ch) : '0;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits <= '0;
        else
            bits <= (bits & ~clr_mask) | set_mask;
    end

    // Pin is low while any flag is set.
    always_comb rdy_n = ~|bits;
endmodule

// File: rtl/mode_sequencer.sv
// Mode sequencer top: holds the control word, launches conversions and
// calibrations on the engine, and posts results as register strobes and
// ready flags. A control write aborts whatever is running.
// Assumes target_ch and rd_ch are below NCH.
module mode_sequencer
    import mseq_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int TW         = 8,
    parameter int CAL_CYCLES = 20,
    localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_q,
    input  logic [NCH-1:0]    ch_enable,
    input  logic [NCH*TW-1:0] ch_conv_time,
    input  logic [CW-1:0]     target_ch,
    input  logic              xtal_clk,
    input  logic              rd_strobe,
    input  logic [CW-1:0]     rd_ch,
    output logic              conv_start,
    output logic [CW-1:0]     conv_ch,
    output logic              conv_done,
    output logic              data_wr,
    output logic [CW-1:0]     data_ch,
    output logic [3:0]        cal_wr,
    output logic [CW-1:0]     cal_ch,
    output logic [NCH-1:0]    ready_bits,
    output logic              ready_n,
    output logic              standby
);
    localparam logic [TW-1:0] CAL_LEN = TW'(CAL_CYCLES);

    mode_e         mode;
    logic          halt, is_cal, is_conv, op_ok, launch, finishing;
    logic          eng_busy, eng_done, pick_found;
    logic [CW-1:0] pick_ch, launch_ch, cur_ch_q, last_q;
    logic [TW-1:0] launch_len;

    // Decode the control word.
    always_comb begin
        mode    = mode_e'(cfg_q[7:MODE_LSB]);
        halt    = cfg_q[CLKOFF_BIT] && xtal_clk;
        is_cal  = cfg_q[7];
        is_conv = (mode == MD_CONT) || (mode == MD_SINGLE);
        standby = (mode == MD_STBY);
    end

    chan_picker #(.NCH(NCH), .CW(CW)) u_pick (
        .last  (last_q),
        .en    (ch_enable),
        .found (pick_found),
        .next  (pick_ch)
    );

    // Launch decision: back-to-back only for continuous scanning.
    always_comb begin
        finishing  = eng_done && !cfg_wr;
        op_ok      = !cfg_wr && !halt &&
                     ((mode == MD_SINGLE) || is_cal ||
                      ((mode == MD_CONT) && pick_found));
        launch     = op_ok && (!eng_busy || (finishing && mode == MD_CONT));
        launch_ch  = (mode == MD_CONT) ? pick_ch : target_ch;
        launch_len = is_cal ? CAL_LEN : ch_conv_time[int'(launch_ch)*TW +: TW];
    end

    conv_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_wr),
        .hold  (halt),
        .start (launch),
        .len   (launch_len),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    // Control word: host writes win; one-shot completions clear the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_wdata;
        else if (finishing && mode != MD_CONT)
            cfg_q[7:MODE_LSB] <= MD_IDLE;
    end

    // Channel being served and scan position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch_q <= '0;
            last_q   <= CW'(NCH - 1);
        end else if (cfg_wr) begin
            last_q   <= CW'(NCH - 1);
        end else if (launch) begin
            cur_ch_q <= launch_ch;
            if (mode == MD_CONT)
                last_q <= pick_ch;
        end
    end

    // Result strobes.
    always_comb begin
        conv_start = launch;
        conv_ch    = launch_ch;
        conv_done  = eng_done;
        data_wr    = finishing && is_conv;
        data_ch    = cur_ch_q;
        cal_wr     = (finishing && is_cal) ? (4'b0001 << cfg_q[6:5]) : 4'b0000;
        cal_ch     = cur_ch_q;
    end

    ready_tracker #(.NCH(NCH), .CW(CW)) u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_one (data_wr),
        .set_ch  (cur_ch_q),
        .set_all (|cal_wr),
        .clr     (rd_strobe),
        .clr_ch  (rd_ch),
        .bits    (ready_bits),
        .rdy_n   (ready_n)
    );
endmodule

// File: rtl/mseq_chk.sv
// Property checker for mode_sequencer, attached by bind below.
// Assumes ch_enable is stable during continuous scanning.
module mseq_chk #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_wr,
    input logic [7:0]     cfg_q,
    input logic [NCH-1:0] ch_enable,
    input logic           xtal_clk,
    input logic           rd_strobe,
    input logic [CW-1:0]  rd_ch,
    input logic           conv_start,
    input logic           conv_done,
    input logic           data_wr,
    input logic [CW-1:0]  data_ch,
    input logic [3:0]     cal_wr,
    input logic [NCH-1:0] ready_bits,
    input logic           ready_n,
    input logic           standby
);
    // R3
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cfg_q[7:5] == 3'd2) |=> (cfg_q[7:5] == 3'd0 && ready_n == 1'b0));

    // R4
    cont_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cfg_q[7:5] == 3'd1) |=> ready_bits[$past(data_ch)]);

    // R6
    no_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[7:5] == 3'd1 && ch_enable == '0) |-> !conv_start);

    // R7
    cal_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_wr != 4'b0000) |=> (&ready_bits && cfg_q[7:5] == 3'd0));

    // R8
    cal_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cal_wr));

    // R9
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !conv_start);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[4] && xtal_clk) |-> (!conv_start && !conv_done));

    // R11
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !data_wr && cal_wr == 4'b0000) |=> !ready_bits[$past(rd_ch)]);

    // R12
    abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (!data_wr && cal_wr == 4'b0000));
endmodule

bind mode_sequencer mseq_chk #(.NCH(NCH), .CW(CW)) u_mseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_q      (cfg_q),
    .ch_enable  (ch_enable),
    .xtal_clk   (xtal_clk),
    .rd_strobe  (rd_strobe),
    .rd_ch      (rd_ch),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .data_wr    (data_wr),
    .data_ch    (data_ch),
    .cal_wr     (cal_wr),
    .ready_bits (ready_bits),
    .ready_n    (ready_n),
    .standby    (standby)
);

// File: tb/mode_sequencer_bench.sv
module mode_sequencer_bench;
    localparam int NCH = 8;
    localparam int TW  = 8;
    localparam int CW  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_q;
    logic [NCH-1:0]    ch_enable = '0;
    logic [NCH*TW-1:0] ch_conv_time;
    logic [CW-1:0]     target_ch = '0;
    logic              xtal_clk = 1'b0;
    logic              rd_strobe = 1'b0;
    logic [CW-1:0]     rd_ch = '0;
    logic              conv_start, conv_done, data_wr, ready_n, standby;
    logic [CW-1:0]     conv_ch, data_ch, cal_ch;
    logic [3:0]        cal_wr;
    logic [NCH-1:0]    ready_bits;

    always #5 clk = ~clk;

    mode_sequencer #(.NCH(NCH), .TW(TW), .CAL_CYCLES(20)) u_mode_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .ch_enable(ch_enable), .ch_conv_time(ch_conv_time),
        .target_ch(target_ch), .xtal_clk(xtal_clk), .rd_strobe(rd_strobe),
        .rd_ch(rd_ch), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_done(conv_done), .data_wr(data_wr), .data_ch(data_ch),
        .cal_wr(cal_wr), .cal_ch(cal_ch), .ready_bits(ready_bits),
        .ready_n(ready_n), .standby(standby)
    );

    // Channel i converts in 4+i cycles.
    always_comb
        for (int i = 0; i < NCH; i++) ch_conv_time[i*TW +: TW] = TW'(4 + i);

    int checks = 0, fails = 0, cyc = 0;
    int n_start = 0, n_data = 0, n_cal = 0, nlog = 0;
    logic [3:0]    last_cal = '0;
    logic [CW-1:0] last_cal_ch = '0;
    int st_ch [16];
    int st_t  [16];

    // Monitor samples 1 ns after each falling edge, after the drivers.
    always @(negedge clk) begin
        #1;
        cyc++;
        if (conv_start) begin
            n_start++;
            if (nlog < 16) begin st_ch[nlog] = int'(conv_ch); st_t[nlog] = cyc; nlog++; end
        end
        if (data_wr) n_data++;
        if (cal_wr != 4'b0000) begin n_cal++; last_cal = cal_wr; last_cal_ch = cal_ch; end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        #2;
    endtask

    task automatic clear_all;
        for (int i = 0; i < NCH; i++) begin
            @(negedge clk); rd_strobe = 1'b1; rd_ch = CW'(i);
        end
        @(negedge clk); rd_strobe = 1'b0;
        #2;
    endtask

    // Fields: mode[30:28] tgt[27:25] en[24:17] rdy[16:9] emode[8:6] ecal[5:2] ndata[1:0]
    localparam logic [30:0] TBL [0:7] = '{
        {3'd2, 3'd2, 8'h00, 8'h04, 3'd0, 4'b0000, 2'd1},
        {3'd2, 3'd7, 8'hFF, 8'h80, 3'd0, 4'b0000, 2'd1},
        {3'd4, 3'd0, 8'h00, 8'hFF, 3'd0, 4'b0001, 2'd0},
        {3'd5, 3'd0, 8'h00, 8'hFF, 3'd0, 4'b0010, 2'd0},
        {3'd6, 3'd3, 8'h00, 8'hFF, 3'd0, 4'b0100, 2'd0},
        {3'd7, 3'd5, 8'h00, 8'hFF, 3'd0, 4'b1000, 2'd0},
        {3'd3, 3'd0, 8'hFF, 8'h00, 3'd3, 4'b0000, 2'd0},
        {3'd0, 3'd0, 8'hFF, 8'h00, 3'd0, 4'b0000, 2'd0}
    };

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd2:       return "R3";
            3'd4, 3'd5: return "R7";
            3'd6, 3'd7: return "R8";
            3'd3:       return "R9";
            default:    return "R2";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int d0, c0, s0;
        string t;
        step(3);
        // R1 reset state
        chk("R1 cfg", 32'(cfg_q), 0);
        chk("R1 ready", 32'(ready_bits), 0);
        chk("R1 ready_n", 32'(ready_n), 1);
        chk("R1 strobes", 32'({conv_start, data_wr, cal_wr}), 0);
        rst_n = 1'b1;
        step(2);

        // Table walk
        for (int r = 0; r < 8; r++) begin
            t = tag_of(TBL[r][30:28]);
            clear_all();
            ch_enable = TBL[r][24:17];
            target_ch = TBL[r][27:25];
            d0 = n_data; c0 = n_cal; s0 = n_start;
            write_cfg({TBL[r][30:28], 5'b0});
            step(40);
            chk({t, " ready"}, 32'(ready_bits), 32'(TBL[r][16:9]));
            chk({t, " mode"}, 32'(cfg_q[7:5]), 32'(TBL[r][8:6]));
            chk({t, " data count"}, n_data - d0, 32'(TBL[r][1:0]));
            chk({t, " cal count"}, n_cal - c0, (TBL[r][5:2] != 0) ? 1 : 0);
            if (TBL[r][5:2] != 0) chk({t, " cal strobe"}, 32'(last_cal), 32'(TBL[r][5:2]));
            if (TBL[r][30:29] == 2'b11) chk({t, " cal ch"}, 32'(last_cal_ch), 32'(TBL[r][27:25]));
            if (TBL[r][30:28] == 3'd3) begin
                chk("R9 standby pin", 32'(standby), 1);
                chk("R9 no start", n_start - s0, 0);
            end
            if (TBL[r][30:28] == 3'd0) chk("R2 idle no start", n_start - s0, 0);
        end
        write_cfg(8'h00);

        // R2 exact timing: single on ch1 (L=5)
        clear_all();
        target_ch = 3'd1;
        write_cfg(8'h40);
        chk("R2 start cycle", 32'(conv_start), 1);
        chk("R2 start ch", 32'(conv_ch), 1);
        step(5);
        chk("R2 data_wr cycle", 32'(data_wr), 1);
        chk("R2 ready not yet", 32'(ready_bits), 0);
        step(1);
        chk("R2 ready set", 32'(ready_bits), 32'h02);
        chk("R11 ready_n low", 32'(ready_n), 0);

        // R11 read clears
        @(negedge clk); rd_strobe = 1'b1; rd_ch = 3'd1;
        @(negedge clk); rd_strobe = 1'b0;
        step(1);
        chk("R11 cleared", 32'(ready_bits), 0);
        chk("R11 ready_n high", 32'(ready_n), 1);

        // R3 other control bits kept
        target_ch = 3'd0;
        write_cfg(8'h4B);
        step(10);
        chk("R3 low bits kept", 32'(cfg_q), 32'h0B);

        // R4/R5 continuous scan over 0,2,5,7 (times 4,6,9,11)
        clear_all();
        ch_enable = 8'hA5;
        nlog = 0;
        write_cfg(8'h20);
        step(70);
        chk("R4 order 0", st_ch[0], 0);
        chk("R4 order 1", st_ch[1], 2);
        chk("R4 order 2", st_ch[2], 5);
        chk("R4 order 3", st_ch[3], 7);
        chk("R4 wrap", st_ch[4], 0);
        chk("R5 period", st_t[4] - st_t[0], 30);
        chk("R4 ready", 32'(ready_bits), 32'hA5);
        chk("R4 mode kept", 32'(cfg_q[7:5]), 1);
        write_cfg(8'h00);

        // R6 continuous with nothing enabled
        clear_all();
        ch_enable = 8'h00;
        s0 = n_start;
        write_cfg(8'h20);
        step(50);
        chk("R6 no start", n_start - s0, 0);
        chk("R6 no ready", 32'(ready_bits), 0);
        chk("R6 mode", 32'(cfg_q[7:5]), 1);
        write_cfg(8'h00);

        // R10 crystal clock with clock-off bit halts; external clock runs
        target_ch = 3'd1;
        xtal_clk = 1'b1;
        s0 = n_start;
        write_cfg(8'h50);
        step(20);
        chk("R10 halted", n_start - s0, 0);
        chk("R10 no ready", 32'(ready_bits), 0);
        xtal_clk = 1'b0;
        step(20);
        chk("R10 runs on external clock", 32'(ready_bits), 32'h02);
        chk("R10 mode cleared", 32'(cfg_q), 32'h10);

        // R12 abort single conversion
        clear_all();
        target_ch = 3'd7;
        d0 = n_data;
        write_cfg(8'h40);
        step(5);
        write_cfg(8'h00);
        step(20);
        chk("R12 no data write", n_data - d0, 0);
        chk("R12 no ready", 32'(ready_bits), 0);

        // R12 abort calibration into another calibration
        c0 = n_cal;
        write_cfg(8'h80);
        step(5);
        target_ch = 3'd2;
        write_cfg(8'hC0);
        step(30);
        chk("R12 one cal write", n_cal - c0, 1);
        chk("R12 new cal strobe", 32'(last_cal), 32'h4);
        chk("R12 new cal ch", 32'(last_cal_ch), 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule